// File: doc/BRIEF.md
# Hash-Indexed Restricted Page Translator

This block translates virtual page numbers (VPNs) for pages that live in a restricted, hash-mapped part of memory. The VPN is folded by XOR down to a set index. Each set holds a small number of ways, and each way is one candidate physical frame. A lookup is one tag compare across the ways of that one set. There is no page-table walk. The physical frame number (PFN) is not stored: it is formed from the set index and the index of the matching way.

When no way matches, the block raises a fallback flag. An external radix-table walker then serves the request from the flexible mapping path. Only pages that software or a placement engine has judged translation-heavy are installed, through a fill port. All other pages always miss here.

A fill picks its way in a fixed order. A way that already holds the same VPN comes first, then the lowest empty way, then the way named by a per-set round-robin pointer. When a fill and a lookup reach the same set in the same cycle, the fill takes effect first.

Top module: `rhx_translator`

## Requirements
- R1: The set index is the XOR of the VPN cut into SET_W-bit chunks, starting from bit 0, with the top chunk zero-padded. With the defaults, this is the XOR of bits [2:0], [5:3], [8:6], [11:9], [14:12] and {2'b00, bit 15}.
- R2: A lookup accepted while `lkp_valid_i` is high gives `rsp_valid_o` high exactly one cycle later. While `rsp_valid_o` is low, `rsp_hit_o`, `rsp_fallback_o` and `rsp_pfn_o` are all zero.
- R3: On a hit, `rsp_hit_o`=1, `rsp_fallback_o`=0, and `rsp_pfn_o` = set_index × WAYS + way_index. That is, the set index sits in the upper SET_W bits and the way index in the lower WAY_W bits.
- R4: On a miss, `rsp_hit_o`=0, `rsp_fallback_o`=1 and `rsp_pfn_o`=0.
- R5: A fill of a VPN that is not present in its set writes the lowest-numbered invalid way of that set.
- R6: A fill of a VPN into a set with every way valid replaces the way named by that set's round-robin pointer. The pointer then advances by one, wrapping at WAYS. Each set has its own pointer.
- R7: A fill of a VPN already present in its set rewrites that same way. It creates no duplicate and leaves the round-robin pointer unchanged.
- R8: A fill and a lookup to the same set in the same cycle are ordered fill-first, so the lookup response reflects the new mapping.
- R9: After reset every way is invalid and every pointer is zero, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request strobe |
| lkp_vpn_i | input | VPN_W | VPN to translate |
| fill_valid_i | input | 1 | Install-mapping strobe |
| fill_vpn_i | input | VPN_W | VPN to install |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_hit_o | output | 1 | Translation found |
| rsp_fallback_o | output | 1 | Not found, send to radix walker |
| rsp_pfn_o | output | SET_W+WAY_W | Physical frame number on hit |

## Verification
The assertions check on every cycle that:
- the response strobe follows the request by one cycle;
- hit and fallback are exclusive;
- idle outputs are zero;
- a hit's upper PFN bits equal the hashed set;
- no set ever holds two valid ways that match one VPN;
- a fill leaves its target way valid;
- an empty-way choice really targets an empty way.

Only the bench scenarios show the rest. These are the exact hash values, the round-robin victim order and per-set pointer independence, eviction of the old mapping, refill without a pointer move, and fill-first visibility within one cycle. The bench checks them by sweeping every set through fill, lookup and miss patterns.

// File: rtl/rhx_pkg.sv
package rhx_pkg;
  typedef enum logic [1:0] {
    VIC_MATCH = 2'd0,  // same VPN already installed
    VIC_FREE  = 2'd1,  // lowest invalid way
    VIC_RR    = 2'd2   // round-robin replacement
  } vic_kind_e;
endpackage

// File: rtl/rhx_hash.sv
module rhx_hash #(
  parameter int VPN_W = 16,
  parameter int SET_W = 3
) (
  input  logic [VPN_W-1:0] vpn_i,
  output logic [SET_W-1:0] set_o
);
  localparam int CHUNKS = (VPN_W + SET_W - 1) / SET_W;
  localparam int PAD_W  = CHUNKS * SET_W;

  logic [PAD_W-1:0] padded;

  always_comb begin
    padded = '0;
    padded[VPN_W-1:0] = vpn_i;
    set_o = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      set_o = set_o ^ padded[c*SET_W +: SET_W];
    end
  end
endmodule

// File: rtl/rhx_victim_sel.sv
module rhx_victim_sel
  import rhx_pkg::*;
#(
  parameter int VPN_W = 16,
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            row_valid_i,
  input  logic [WAYS-1:0][VPN_W-1:0] row_tag_i,
  input  logic [VPN_W-1:0]           vpn_i,
  input  logic [WAY_W-1:0]           rr_ptr_i,
  output logic [WAY_W-1:0]           way_o,
  output vic_kind_e                  kind_o
);
  logic             match_found, free_found;
  logic [WAY_W-1:0] match_way, free_way;

  always_comb begin
    match_found = 1'b0;
    free_found  = 1'b0;
    match_way   = '0;
    free_way    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!match_found && row_valid_i[w] && row_tag_i[w] == vpn_i) begin
        match_found = 1'b1;
        match_way   = WAY_W'(w);
      end
      if (!free_found && !row_valid_i[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
    if (match_found) begin
      way_o  = match_way;
      kind_o = VIC_MATCH;
    end else if (free_found) begin
      way_o  = free_way;
      kind_o = VIC_FREE;
    end else begin
      way_o  = rr_ptr_i;
      kind_o = VIC_RR;
    end
  end
endmodule

// File: rtl/rhx_tag_store.sv
module rhx_tag_store #(
  parameter int VPN_W = 16,
  parameter int SET_W = 3,
  parameter int WAYS  = 4,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SET_W-1:0]           lk_set_i,
  output logic [WAYS-1:0]            lk_valid_o,
  output logic [WAYS-1:0][VPN_W-1:0] lk_tag_o,
  input  logic [SET_W-1:0]           fl_set_i,
  output logic [WAYS-1:0]            fl_valid_o,
  output logic [WAYS-1:0][VPN_W-1:0] fl_tag_o,
  output logic [WAY_W-1:0]           fl_rr_o,
  input  logic                       wr_en_i,
  input  logic [WAY_W-1:0]           wr_way_i,
  input  logic [VPN_W-1:0]           wr_tag_i,
  input  logic                       rr_adv_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [VPN_W-1:0] tag_q   [SETS][WAYS];
  logic [WAY_W-1:0] rr_q    [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[fl_set_i][wr_way_i] <= 1'b1;
      if (rr_adv_i) rr_q[fl_set_i] <= rr_q[fl_set_i] + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[fl_set_i][wr_way_i] <= wr_tag_i;
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_tag_o[w] = tag_q[lk_set_i][w];
      fl_tag_o[w] = tag_q[fl_set_i][w];
    end
    lk_valid_o = valid_q[lk_set_i];
    fl_valid_o = valid_q[fl_set_i];
    fl_rr_o    = rr_q[fl_set_i];
  end

  p_fill_sets_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(fl_set_i)][$past(wr_way_i)]);
endmodule

// File: rtl/rhx_translator.sv
module rhx_translator
  import rhx_pkg::*;
#(
  parameter int VPN_W = 16,
  parameter int SET_W = 3,
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PFN_W = SET_W + WAY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_fallback_o,
  output logic [PFN_W-1:0] rsp_pfn_o
);
  logic [SET_W-1:0]           lk_set, fl_set;
  logic [WAYS-1:0]            lk_valid, fl_valid, eff_valid;
  logic [WAYS-1:0][VPN_W-1:0] lk_tag, fl_tag, eff_tag;
  logic [WAY_W-1:0]           fl_rr, fl_way, hit_way;
  vic_kind_e                  fl_kind;
  logic [WAYS-1:0]            match;
  logic                       any_hit;

  rhx_hash #(.VPN_W(VPN_W), .SET_W(SET_W)) i_hash_lk (.vpn_i(lkp_vpn_i),  .set_o(lk_set));
  rhx_hash #(.VPN_W(VPN_W), .SET_W(SET_W)) i_hash_fl (.vpn_i(fill_vpn_i), .set_o(fl_set));

  rhx_tag_store #(.VPN_W(VPN_W), .SET_W(SET_W), .WAYS(WAYS)) i_store (
    .clk_i, .rst_ni,
    .lk_set_i(lk_set), .lk_valid_o(lk_valid), .lk_tag_o(lk_tag),
    .fl_set_i(fl_set), .fl_valid_o(fl_valid), .fl_tag_o(fl_tag), .fl_rr_o(fl_rr),
    .wr_en_i(fill_valid_i), .wr_way_i(fl_way), .wr_tag_i(fill_vpn_i),
    .rr_adv_i(fl_kind == VIC_RR)
  );

  rhx_victim_sel #(.VPN_W(VPN_W), .WAYS(WAYS)) i_vsel (
    .row_valid_i(fl_valid), .row_tag_i(fl_tag), .vpn_i(fill_vpn_i),
    .rr_ptr_i(fl_rr), .way_o(fl_way), .kind_o(fl_kind)
  );

  // Fill-first: overlay the way being written onto the lookup row.
  always_comb begin
    eff_valid = lk_valid;
    eff_tag   = lk_tag;
    if (fill_valid_i && fl_set == lk_set) begin
      eff_valid[fl_way] = 1'b1;
      eff_tag[fl_way]   = fill_vpn_i;
    end
    any_hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = eff_valid[w] && eff_tag[w] == lkp_vpn_i;
      if (match[w] && !any_hit) begin
        any_hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_hit_o      <= 1'b0;
      rsp_fallback_o <= 1'b0;
      rsp_pfn_o      <= '0;
    end else begin
      rsp_valid_o    <= lkp_valid_i;
      rsp_hit_o      <= lkp_valid_i && any_hit;
      rsp_fallback_o <= lkp_valid_i && !any_hit;
      rsp_pfn_o      <= (lkp_valid_i && any_hit) ? {lk_set, hit_way} : '0;
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(lkp_valid_i));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_fallback_o && rsp_pfn_o == '0));
  p_hit_xor_fallback_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o != rsp_fallback_o));
  p_pfn_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> (!rsp_hit_o || rsp_pfn_o[PFN_W-1:WAY_W] == $past(lk_set)));
  p_no_duplicate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  p_free_way_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fl_kind == VIC_FREE) |-> !fl_valid[fl_way]);
endmodule

// File: tb/test_rhx_translator.sv
module test_rhx_translator;
  localparam int VPN_W = 16;
  localparam int SET_W = 3;
  localparam int WAYS  = 4;
  localparam int SETS  = 1 << SET_W;
  localparam int PFN_W = SET_W + 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lkp_valid = 1'b0, fill_valid = 1'b0;
  logic [VPN_W-1:0] lkp_vpn = '0, fill_vpn = '0;
  logic             rsp_valid, rsp_hit, rsp_fallback;
  logic [PFN_W-1:0] rsp_pfn;
  int               n_chk = 0, n_fail = 0;
  bit               done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rhx_translator #(.VPN_W(VPN_W), .SET_W(SET_W), .WAYS(WAYS)) i_rhx_translator (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vpn_i(lkp_vpn),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .rsp_fallback_o(rsp_fallback), .rsp_pfn_o(rsp_pfn)
  );

  // R1: XOR of 3-bit chunks, top chunk zero-padded
  function automatic int hash_b(int vpn);
    int h = 0;
    for (int c = 0; c < 6; c++) h = h ^ ((vpn >> (3 * c)) & 7);
    return h;
  endfunction

  // n-th VPN (from 1 upward) that hashes to set s
  function automatic int vpn_of(int s, int n);
    int k = 0;
    for (int v = 1; v < 65536; v++) begin
      if (hash_b(v) == s) begin
        if (k == n) return v;
        k++;
      end
    end
    return 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(int vpn);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = VPN_W'(vpn);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // optional same-cycle fill; response sampled one negedge later
  task automatic lookup(int vpn, bit hit, int pfn, string req, bit with_fill = 0, int fvpn = 0);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vpn = VPN_W'(vpn);
    fill_valid = with_fill; fill_vpn = VPN_W'(fvpn);
    @(negedge clk);
    lkp_valid = 1'b0; fill_valid = 1'b0;
    check(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
    check(rsp_hit == hit, req, "hit", rsp_hit, hit);
    check(rsp_fallback == !hit, req, "fallback", rsp_fallback, !hit);
    check(rsp_pfn == PFN_W'(hit ? pfn : 0), req, "pfn", rsp_pfn, hit ? pfn : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && rsp_hit == 0 && rsp_fallback == 0, "R9", "reset outputs", rsp_valid, 0);
    rst_n = 1'b1;
    // R9: empty after reset
    for (int s = 0; s < SETS; s++) lookup(vpn_of(s, 0), 0, 0, "R9");
    @(negedge clk);
    check(rsp_valid == 0 && rsp_pfn == 0 && !rsp_hit && !rsp_fallback, "R2", "idle outputs", rsp_valid, 0);
    // R5/R3/R1: fill every way of every set, then look up each
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) fill(vpn_of(s, w));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) lookup(vpn_of(s, w), 1, s * WAYS + w, "R3 R5 R1");
    // R4: absent VPNs miss
    for (int s = 0; s < SETS; s++) lookup(vpn_of(s, 10), 0, 0, "R4");
    // R6: round-robin in set 2
    fill(vpn_of(2, 4));
    fill(vpn_of(2, 5));
    lookup(vpn_of(2, 4), 1, 8, "R6");
    lookup(vpn_of(2, 5), 1, 9, "R6");
    lookup(vpn_of(2, 0), 0, 0, "R6 evicted");
    lookup(vpn_of(2, 2), 1, 10, "R6");
    // R7: refill present VPN keeps way and pointer
    fill(vpn_of(2, 3));
    lookup(vpn_of(2, 3), 1, 11, "R7");
    fill(vpn_of(2, 6));
    lookup(vpn_of(2, 6), 1, 10, "R7 pointer");
    lookup(vpn_of(2, 3), 1, 11, "R7");
    lookup(vpn_of(2, 2), 0, 0, "R7 evicted");
    // R6: other set's pointer still at zero
    fill(vpn_of(3, 4));
    lookup(vpn_of(3, 4), 1, 12, "R6 per-set");
    lookup(vpn_of(3, 1), 1, 13, "R6 per-set");
    // R8: same-cycle fill and lookup
    lookup(vpn_of(5, 7), 1, 20, "R8", 1, vpn_of(5, 7));
    lookup(vpn_of(5, 0), 0, 0, "R8 evicted");
    lookup(vpn_of(1, 2), 1, 6, "R8 other set", 1, vpn_of(7, 8));
    lookup(vpn_of(7, 8), 1, 28, "R8 installed");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule